// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters on a single line. It runs from a strobe that pulses sixteen times per bit period. A low level on the line starts a frame. The block confirms the start bit half a bit later, then collects 5 to 8 data bits, least significant first. After the data come an optional parity bit and a stop bit. Every completed frame goes into a receive queue as a 12-bit entry. The low byte holds the character and the upper four bits hold that character's own error flags, so software reads the data and its status in one access.

Frame settings (word length, parity enable and sense) and the queue settings (queue enable and receive trigger level) are plain inputs, driven by the surrounding line-control logic. A read strobe removes the oldest entry, which is always visible on the read-data output. The block reports empty and full in an 8-bit flag word. It raises three interrupt requests: a level request when the queue reaches the trigger level, a timeout request when data sits unread on a quiet line, and an error request when the oldest entry carries any error flag. Nothing on the transmit side is part of this block.

Top module: `uart_rx_fifo`

## Requirements
- R1: Frame reception.
  - On a strobe with the line low, the receiver starts a frame and re-checks the line 8 strobes later. A high line there abandons the frame.
  - Otherwise it samples 5, 6, 7 or 8 data bits (word_len = 0, 1, 2, 3), one every 16 strobes, least significant first.
  - It then samples the parity bit if enabled, then the stop bit.
  - The character appears in rd_data[7:0], zero-extended above the word length.
- R2: Flags. flags[4] is 1 when the queue is empty and flags[6] is 1 when it is full. All other flag bits are 0.
- R3: Parity. With parity_en = 1, rd_data[9] is set when the count of ones over the data and parity bits is odd while parity_even = 1, or even while parity_even = 0. With parity_en = 0 no parity bit is expected and rd_data[9] stays 0.
- R4: Framing error. A low stop bit on a frame that is not a break sets rd_data[8].
- R5: Break.
  - A frame whose start bit, data bits, parity bit and stop bit are all low stores one entry: character 0, rd_data[10] = 1, and rd_data[9:8] = 0.
  - No further entry is stored until the line has returned high.
- R6: Overrun. A frame that completes while the queue is full is discarded. It sets rd_data[11] on the most recently stored entry.
- R7: With fifo_en = 1 the queue holds DEPTH (32) entries in arrival order. A rd_en pulse while not empty removes exactly the oldest entry.
- R8: With fifo_en = 0 the queue holds a single entry and reads full as soon as it holds one.
- R9: Receive interrupt level.
  - With fifo_en = 1, irq_rx is high while the entry count is at least the threshold selected by rx_level.
  - The thresholds are 0 → DEPTH/8, 1 → DEPTH/4, 2 → DEPTH/2, 3 → 3·DEPTH/4, and 4 to 7 → 7·DEPTH/8 (4, 8, 16, 24, 28 for DEPTH = 32).
  - With fifo_en = 0, irq_rx is high while an entry is held.
- R10: Timeout. irq_timeout is high while the queue is not empty and no frame has completed for 32 bit periods (512 strobes).
- R11: irq_err is high while the oldest entry has any of rd_data[11:8] set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| fifo_en | input | 1 | 1: full-depth queue, 0: single holding entry |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit expected |
| parity_even | input | 1 | 1: even parity, 0: odd parity |
| rx_level | input | 3 | Receive trigger level code |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 12 | Oldest entry: {overrun, break, parity err, framing err, char} |
| flags | output | 8 | Status word: bit 4 empty, bit 6 full |
| irq_rx | output | 1 | Queue at or above trigger level |
| irq_timeout | output | 1 | Unread data on a quiet line |
| irq_err | output | 1 | Oldest entry carries an error flag |

## Verification
The bench covers every word length against every parity mode. It injects bad parity bits and low stop bits, so a receiver that miscounts data bits or inverts the parity sense returns wrong low bytes or misplaced error flags. A held-low line must produce exactly one break entry. A receiver that re-arms while the line stays low would store a stream of breaks.

The queue is filled past capacity in both depth settings. A design that overwrites the head, stores the extra character, or flags the wrong entry shows up in the drained sequence. During the drain, irq_rx is compared against all eight trigger codes at every occupancy. The timeout request is checked on both sides of its 32-bit-period window and after the queue empties.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH   = 32,
  parameter int TO_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baud_tick,
  input  logic        rxd,
  input  logic        fifo_en,
  input  logic [1:0]  word_len,
  input  logic        parity_en,
  input  logic        parity_even,
  input  logic [2:0]  rx_level,
  input  logic        rd_en,
  output logic [11:0] rd_data,
  output logic [7:0]  flags,
  output logic        irq_rx,
  output logic        irq_timeout,
  output logic        irq_err
);
  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int TO_TICKS = TO_BITS * 16;
  localparam int TW       = $clog2(TO_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [3:0] cnt;
  logic [2:0] nb;
  logic [7:0] sh;
  logic       par, zero;

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, cap, thr;
  logic [TW-1:0] quiet;

  logic        push, pop, full, empty, wr, brk, fe, pe;
  logic [7:0]  ch;
  logic [11:0] new_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nb <= '0; sh <= '0; par <= 1'b0; zero <= 1'b0;
    end else begin
      if (baud_tick) cnt <= cnt + 4'd1;
      case (st)
        S_IDLE:  if (baud_tick && !rxd) begin st <= S_START; cnt <= '0; end
        S_START: if (baud_tick && cnt == 4'd7) begin
                   cnt <= '0; nb <= '0; par <= 1'b0; zero <= 1'b1;
                   st <= rxd ? S_IDLE : S_DATA;
                 end
        S_DATA:  if (baud_tick && cnt == 4'd15) begin
                   sh <= {rxd, sh[7:1]};
                   par <= par ^ rxd;
                   zero <= zero & ~rxd;
                   nb <= nb + 3'd1;
                   if (nb == {1'b1, word_len}) st <= parity_en ? S_PAR : S_STOP;
                 end
        S_PAR:   if (baud_tick && cnt == 4'd15) begin
                   par <= par ^ rxd;
                   zero <= zero & ~rxd;
                   st <= S_STOP;
                 end
        S_STOP:  if (baud_tick && cnt == 4'd15) st <= rxd ? S_IDLE : S_HOLD;
        S_HOLD:  if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign push     = (st == S_STOP) && baud_tick && (cnt == 4'd15);
  assign brk      = zero && !rxd;
  assign fe       = !rxd && !zero;
  assign pe       = !brk && parity_en && (par ^ !parity_even);
  assign ch       = sh >> (2'd3 - word_len);
  assign new_word = {1'b0, brk, pe, fe, brk ? 8'h00 : ch};

  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign empty = (count == '0);
  assign full  = (count == cap);
  assign pop   = rd_en && !empty;
  assign wr    = push && !full;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= new_word;
    else if (push) mem[wp - AW'(1)][11] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; quiet <= '0;
    end else begin
      if (wr) wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      count <= count + CW'(wr) - CW'(pop);
      if (push) quiet <= '0;
      else if (baud_tick && quiet != TW'(TO_TICKS)) quiet <= quiet + TW'(1);
    end
  end

  always_comb begin
    case (rx_level)
      3'd0:    thr = CW'(DEPTH / 8);
      3'd1:    thr = CW'(DEPTH / 4);
      3'd2:    thr = CW'(DEPTH / 2);
      3'd3:    thr = CW'(DEPTH * 3 / 4);
      default: thr = CW'(DEPTH * 7 / 8);
    endcase
  end

  assign rd_data     = mem[rp];
  assign flags       = {1'b0, full, 1'b0, empty, 4'b0};
  assign irq_rx      = fifo_en ? (count >= thr) : !empty;
  assign irq_timeout = !empty && (quiet == TW'(TO_TICKS));
  assign irq_err     = !empty && (rd_data[11:8] != 4'b0);
endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [7:0]                 flags,
  input logic                       rd_en,
  input logic [11:0]                rd_data,
  input logic                       irq_timeout,
  input logic                       fifo_en,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       push
);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[4] && flags[6]));

  assert_timeout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> !flags[4]);

  assert_head_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !flags[4]) |=> $stable(rd_data[7:0]));

  assert_last_pop_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && count == 1 && !push) |=> flags[4]);

  assert_single_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && count <= 1) |=> (!fifo_en -> count <= 1));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .rd_en(rd_en), .rd_data(rd_data),
  .irq_timeout(irq_timeout), .fifo_en(fifo_en), .count(count), .push(push)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic fifo_en = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic parity_en = 1'b0, parity_even = 1'b0;
  logic [2:0] rx_level = 3'd0;
  logic rd_en = 1'b0;
  logic [11:0] rd_data;
  logic [7:0] flags;
  logic irq_rx, irq_timeout, irq_err;
  logic [1:0] tdiv = 2'd0;
  logic baud_tick;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .fifo_en(fifo_en),
    .word_len(word_len), .parity_en(parity_en), .parity_even(parity_even),
    .rx_level(rx_level), .rd_en(rd_en), .rd_data(rd_data), .flags(flags),
    .irq_rx(irq_rx), .irq_timeout(irq_timeout), .irq_err(irq_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rxd = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] c, input int wl, input int pm,
                            input bit bad_par, input bit stop_bit);
    logic [7:0] m;
    logic p;
    m = c & 8'((1 << (wl + 5)) - 1);
    word_len = wl[1:0];
    parity_en = (pm != 0);
    parity_even = (pm == 2);
    bit_out(1'b0);
    for (int i = 0; i < wl + 5; i++) bit_out(m[i]);
    if (pm != 0) begin
      p = ^m;
      if (pm == 1) p = ~p;
      bit_out(p ^ bad_par);
    end
    bit_out(stop_bit);
    bit_out(1'b1);
  endtask

  task automatic pop;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  function automatic int thr_of(input int lvl);
    case (lvl)
      0: return 4;
      1: return 8;
      2: return 16;
      3: return 24;
      default: return 28;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] chars [3];
    logic [7:0] m;
    logic [11:0] exp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2 reset flags", flags, 8'h10);
    check("R9 reset irq_rx", irq_rx, 0);
    check("R10 reset irq_timeout", irq_timeout, 0);
    check("R11 reset irq_err", irq_err, 0);

    // R1 R3: all word lengths x parity modes, holding register mode
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++) begin
        chars[0] = 8'h5A; chars[1] = 8'hC3; chars[2] = 8'h81 ^ 8'(wl);
        for (int k = 0; k < 3; k++) begin
          bit bad;
          bad = (pm != 0) && (k == 2);
          send_frame(chars[k], wl, pm, bad, 1'b1);
          m = chars[k] & 8'((1 << (wl + 5)) - 1);
          exp = {2'b00, bad, 1'b0, m};
          check("R1 char", {20'b0, rd_data[7:0]}, {24'b0, m});
          check("R3 parity flag", rd_data, exp);
          check("R11 irq_err", irq_err, bad);
          check("R8 full with one entry", flags, 8'h40);
          check("R9 irq_rx held", irq_rx, 1);
          pop();
          check("R7 empty after pop", flags, 8'h10);
        end
      end

    // R4 framing error
    send_frame(8'h55, 3, 0, 0, 1'b0);
    check("R4 framing flag", rd_data, 12'h155);
    check("R11 irq_err framing", irq_err, 1);
    pop();

    // R5 break: line low for 12 bit periods
    word_len = 2'd3; parity_en = 1'b0;
    rxd = 1'b0;
    repeat (12 * 64) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    #1;
    check("R5 break entry", rd_data, 12'h400);
    check("R11 irq_err break", irq_err, 1);
    pop();
    check("R5 single break entry", flags, 8'h10);

    // R8 overrun in holding mode
    send_frame(8'h11, 3, 0, 0, 1'b1);
    send_frame(8'h22, 3, 0, 0, 1'b1);
    check("R8 R6 overrun on held entry", rd_data, 12'h811);
    pop();
    check("R8 second char dropped", flags, 8'h10);

    // R7 R6 R9: full-depth queue
    fifo_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      send_frame(8'(i * 7 + 1), 3, 0, 0, 1'b1);
      if (i == 0) check("R9 below level 4", irq_rx, 0);
    end
    check("R2 full flag", flags, 8'h40);
    send_frame(8'hEE, 3, 0, 0, 1'b1);
    check("R2 still full after overrun", flags, 8'h40);
    for (int k = 0; k < 32; k++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        rx_level = 3'(lvl);
        #1;
        check("R9 trigger level", irq_rx, ((32 - k) >= thr_of(lvl)) ? 1 : 0);
      end
      exp = {(k == 31) ? 4'h8 : 4'h0, 8'(k * 7 + 1)};
      check("R7 R6 drain order", rd_data, exp);
      pop();
    end
    check("R7 empty after drain", flags, 8'h10);

    // R10 timeout
    send_frame(8'h3C, 3, 0, 0, 1'b1);
    check("R10 no early timeout", irq_timeout, 0);
    repeat (2100) @(negedge clk);
    #1;
    check("R10 timeout fires", irq_timeout, 1);
    check("R10 data intact", rd_data, 12'h03C);
    pop();
    check("R10 timeout clears when empty", irq_timeout, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule